// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block derives every digital drive clock for a three-color linear CCD sensor from one master clock. Each line begins with a transfer-gate pulse, shared by all three color rows, that moves the photocell charge into the shift registers. A short quiet gap follows. Then the two-phase shift clocks, the last-stage clock, the reset gate and the clamp clock run through the line readout. Timing is counted in master-clock ticks, and four ticks make one pixel period.

A static mode input picks between two clamp schemes. In per-pixel (bit) clamping, a clamp pulse follows every reset pulse. In per-line clamping, the clamp is held low across the transfer event and reset pulses are masked while it is low. A valid-pixel strobe and a zero-based pixel index frame the image pixels of each line for a downstream ADC capture. The line period and the transfer-gate width are static inputs in ticks. The readout order is fixed by parameters: leading dummy pixels, 49 optical-black pixels, 2 invalid pixels, the image pixels, then trailing invalid pixels up to the end of the line.

Top module: `ccd_line_timer`

## Requirements
- R1: While `rst` is high, after a clock edge, `phi2_o` is 1 and every other output (`tg_o`, `phi1_o`, `phi1_last_o`, `rg_o`, `clamp_o`, `pix_valid_o`) is 0, with `pix_idx_o` equal to 0. This holds even when reset is asserted in the middle of a line.
- R2: Count the rising clock edges after `rst` falls, starting at 1 and letting L be `line_ticks`. `tg_o` first goes high after edge L+1 and repeats every L edges after that. Each pulse lasts `tg_ticks` cycles.
- R3: During readout, count ticks from the start of readout (POST_TICKS ticks after `tg_o` falls) and group them in fours. `phi1_o` and `phi1_last_o` are high on ticks 0 and 1 of each group, and `phi2_o` is high on ticks 2 and 3. `phi1_o` and `phi2_o` are always complementary.
- R4: From the start of the transfer-gate pulse to the end of the post-transfer gap, the shift clocks are static: `phi1_o` and `phi1_last_o` are 1 and `phi2_o` is 0.
- R5: In bit clamp mode (`line_mode` = 0), `rg_o` and `clamp_o` are both high for the whole transfer-gate pulse and both low during the gap. During readout, `rg_o` is high on tick 0 and `clamp_o` is high on tick 1.
- R6: In line clamp mode (`line_mode` = 1), `clamp_o` is low from the start of the transfer-gate pulse to the end of the gap and high through readout. `rg_o` is low whenever `clamp_o` is low, and pulses on tick 0 during readout.
- R7: `pix_valid_o` is high for one tick (tick 2) of each readout pixel numbered FIRST through FIRST+VALID_PIX-1, counting readout pixels from 0, where FIRST = LEAD_PIX + 49 + 2. While it is high, `pix_idx_o` equals the pixel number minus FIRST. Otherwise `pix_idx_o` is 0.
- R8: During the first line period after reset is released, all outputs stay at their reset levels.
- R9: If the line period ends before the readout sequence completes, the readout is cut short: strobes stop at the last image pixel whose tick 2 falls inside the line, and the next transfer gate still starts on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| line_mode | input | 1 | 0 = per-pixel clamping, 1 = per-line clamping |
| line_ticks | input | LINE_W (18) | Line period in ticks (static) |
| tg_ticks | input | TG_W (12) | Transfer-gate width in ticks (static) |
| tg_o | output | 1 | Transfer-gate pulse for all three colors |
| phi1_o | output | 1 | Shift phase 1 |
| phi1_last_o | output | 1 | Last-stage shift clock |
| phi2_o | output | 1 | Shift phase 2 |
| rg_o | output | 1 | Reset gate pulse |
| clamp_o | output | 1 | Clamp clock |
| pix_valid_o | output | 1 | Image-pixel strobe |
| pix_idx_o | output | IDX_W (13) | Image-pixel index, zero based |

## Verification
The bench targets the edges of the line. It checks the exact edge on which the first transfer gate appears, since a design that fires during the first line would charge-dump an unsettled sensor. It checks the boundary between the post-transfer gap and the first shift tick: an off-by-one there would either clock the register while the gate is still open or push every pixel one tick later. It uses a one-tick transfer gate, and it uses lines that are too short for the full readout, which would expose a design that keeps strobing past the line end or skips the next transfer gate. In line clamp mode, a design that lets reset pulses leak through the clamp-low window, or clamps during readout, shows up as mismatches on `rg_o` and `clamp_o`.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int LEAD_PIX   = 13,
  parameter int DARK_PIX   = 49,
  parameter int SKIP_PIX   = 2,
  parameter int VALID_PIX  = 5400,
  parameter int POST_TICKS = 8,
  parameter int LINE_W     = 18,
  parameter int TG_W       = 12,
  parameter int IDX_W      = $clog2(VALID_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_mode,
  input  logic [LINE_W-1:0] line_ticks,
  input  logic [TG_W-1:0]   tg_ticks,
  output logic              tg_o,
  output logic              phi1_o,
  output logic              phi1_last_o,
  output logic              phi2_o,
  output logic              rg_o,
  output logic              clamp_o,
  output logic              pix_valid_o,
  output logic [IDX_W-1:0]  pix_idx_o
);

  localparam int FIRST_VALID = LEAD_PIX + DARK_PIX + SKIP_PIX;
  localparam logic [LINE_W:0] FV   = (LINE_W+1)'(FIRST_VALID);
  localparam logic [LINE_W:0] LV   = (LINE_W+1)'(FIRST_VALID + VALID_PIX);
  localparam logic [LINE_W:0] POST = (LINE_W+1)'(POST_TICKS);

  logic [LINE_W-1:0] tcnt;
  logic              warm;
  logic              line_end;
  logic [LINE_W:0]   t_ext, tg_ext, rd_start, rel, pix;
  logic [1:0]        ph;
  logic              in_tg, in_gap, shifting, valid_n;

  assign line_end = tcnt >= line_ticks - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      warm <= 1'b0;
    end else if (line_end) begin
      tcnt <= '0;
      warm <= 1'b1;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign t_ext    = {1'b0, tcnt};
  assign tg_ext   = (LINE_W+1)'(tg_ticks);
  assign rd_start = tg_ext + POST;
  assign rel      = t_ext - rd_start;
  assign ph       = rel[1:0];
  assign pix      = {2'b00, rel[LINE_W:2]};

  assign in_tg    = warm && (t_ext < tg_ext);
  assign in_gap   = warm && !in_tg && (t_ext < rd_start);
  assign shifting = warm && !in_tg && !in_gap;
  assign valid_n  = shifting && (ph == 2'd2) && (pix >= FV) && (pix < LV);

  always_ff @(posedge clk) begin
    if (rst) begin
      tg_o        <= 1'b0;
      phi1_o      <= 1'b0;
      phi1_last_o <= 1'b0;
      phi2_o      <= 1'b1;
      rg_o        <= 1'b0;
      clamp_o     <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_idx_o   <= '0;
    end else begin
      tg_o        <= in_tg;
      phi1_o      <= warm && !(shifting && ph[1]);
      phi1_last_o <= (in_tg || in_gap) || (shifting && !ph[1]);
      phi2_o      <= !warm || (shifting && ph[1]);
      rg_o        <= (in_tg && !line_mode) || (shifting && ph == 2'd0);
      clamp_o     <= line_mode ? shifting : (in_tg || (shifting && ph == 2'd1));
      pix_valid_o <= valid_n;
      pix_idx_o   <= valid_n ? IDX_W'(pix - FV) : '0;
    end
  end

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic clk,
  input logic rst,
  input logic line_mode,
  input logic tg_o,
  input logic phi1_o,
  input logic phi1_last_o,
  input logic phi2_o,
  input logic rg_o,
  input logic clamp_o,
  input logic pix_valid_o
);

  a_r3_phases_complementary: assert property (@(posedge clk) disable iff (rst)
    phi1_o != phi2_o);

  a_r3_last_stage_tracks_phi1: assert property (@(posedge clk) disable iff (rst)
    phi2_o |-> !phi1_last_o);

  a_r4_shift_static_in_tg: assert property (@(posedge clk) disable iff (rst)
    (tg_o && $past(tg_o)) |-> ($stable(phi1_o) && $stable(phi2_o)));

  a_r5_bit_tg_holds_rg_clamp: assert property (@(posedge clk) disable iff (rst)
    (!line_mode && tg_o) |-> (rg_o && clamp_o));

  a_r5_bit_no_overlap_outside_tg: assert property (@(posedge clk) disable iff (rst)
    (!line_mode && !tg_o) |-> !(rg_o && clamp_o));

  a_r6_line_clamp_low_in_tg: assert property (@(posedge clk) disable iff (rst)
    (line_mode && tg_o) |-> !clamp_o);

  a_r6_line_reset_masked: assert property (@(posedge clk) disable iff (rst)
    (line_mode && !clamp_o) |-> !rg_o);

  a_r7_strobe_in_readout: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> (!tg_o && phi2_o && !rg_o));

endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (
  .clk(clk), .rst(rst), .line_mode(line_mode), .tg_o(tg_o),
  .phi1_o(phi1_o), .phi1_last_o(phi1_last_o), .phi2_o(phi2_o),
  .rg_o(rg_o), .clamp_o(clamp_o), .pix_valid_o(pix_valid_o)
);

// File: tb/ccd_line_timer_tb.sv
module ccd_line_timer_tb;

  localparam int NVAL   = 40;
  localparam int POST   = 8;
  localparam int FIRSTV = 13 + 49 + 2;
  localparam int IW     = $clog2(NVAL);
  localparam int NSC    = 5;

  localparam int SC_MODE[NSC]    = '{0, 1, 0, 1, 0};
  localparam int SC_LEN[NSC]     = '{500, 500, 600, 200, 350};
  localparam int SC_TG[NSC]      = '{20, 20, 1, 12, 8};
  localparam int SC_STROBES[NSC] = '{80, 80, 80, 0, 38};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_mode = 1'b0;
  logic [17:0] line_ticks = 18'd500;
  logic [11:0] tg_ticks = 12'd20;
  logic tg_o, phi1_o, phi1_last_o, phi2_o, rg_o, clamp_o, pix_valid_o;
  logic [IW-1:0] pix_idx_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  ccd_line_timer #(.VALID_PIX(NVAL), .POST_TICKS(POST)) u_dut (
    .clk(clk), .rst(rst), .line_mode(line_mode), .line_ticks(line_ticks),
    .tg_ticks(tg_ticks), .tg_o(tg_o), .phi1_o(phi1_o), .phi1_last_o(phi1_last_o),
    .phi2_o(phi2_o), .rg_o(rg_o), .clamp_o(clamp_o), .pix_valid_o(pix_valid_o),
    .pix_idx_o(pix_idx_o)
  );

  typedef struct packed {
    logic tg, p1, p1l, p2, rg, cl, st;
    logic [IW-1:0] ix;
  } outs_t;

  function automatic outs_t model(int k, bit mode, int len, int tg);
    outs_t e;
    int t, rel, ph, pix;
    t = (k - 1) % len;
    e = '0;
    e.p2 = 1'b1;
    if (k - 1 < len) return e;
    if (t < tg) begin
      e.tg = 1; e.p1 = 1; e.p1l = 1; e.p2 = 0; e.rg = !mode; e.cl = !mode;
    end else if (t < tg + POST) begin
      e.p1 = 1; e.p1l = 1; e.p2 = 0;
    end else begin
      rel = t - tg - POST; ph = rel % 4; pix = rel / 4;
      e.p1 = (ph < 2); e.p1l = (ph < 2); e.p2 = (ph >= 2);
      e.rg = (ph == 0);
      e.cl = mode ? 1'b1 : (ph == 1);
      e.st = (ph == 2) && pix >= FIRSTV && pix < FIRSTV + NVAL;
      e.ix = e.st ? IW'(pix - FIRSTV) : '0;
    end
    return e;
  endfunction

  function automatic outs_t got();
    return '{tg_o, phi1_o, phi1_last_o, phi2_o, rg_o, clamp_o, pix_valid_o, pix_idx_o};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_reset_levels(string what);
    outs_t g, e;
    g = got();
    e = '0;
    e.p2 = 1'b1;
    check(g == e, "R1", what, int'(g), int'(e));
  endtask

  task automatic start(int i);
    @(negedge clk);
    rst = 1'b1;
    line_mode = SC_MODE[i][0];
    line_ticks = 18'(SC_LEN[i]);
    tg_ticks = 12'(SC_TG[i]);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_scenario(int i);
    int len, rise, strobes, m_tg, m_win, m_rd, m_rc, m_st, m_first;
    bit mode;
    outs_t g, e;
    len = SC_LEN[i];
    mode = SC_MODE[i][0];
    rise = -1; strobes = 0;
    m_tg = 0; m_win = 0; m_rd = 0; m_rc = 0; m_st = 0; m_first = 0;
    start(i);
    for (int k = 1; k <= 3 * len; k++) begin
      @(posedge clk);
      @(negedge clk);
      g = got();
      e = model(k, mode, len, SC_TG[i]);
      if (g.tg && rise < 0) rise = k;
      if (g.st) strobes++;
      if (k - 1 < len) begin
        if (g != e) m_first++;
      end else begin
        if (g.tg != e.tg) m_tg++;
        if ({g.p1, g.p1l, g.p2} != {e.p1, e.p1l, e.p2}) begin
          if ((k - 1) % len < SC_TG[i] + POST) m_win++; else m_rd++;
        end
        if ({g.rg, g.cl} != {e.rg, e.cl}) m_rc++;
        if ({g.st, g.ix} != {e.st, e.ix}) m_st++;
      end
    end
    // R8: first line idle, R2: transfer-gate timing and width
    check(m_first == 0, "R8", "first-line mismatches", m_first, 0);
    check(rise == len + 1, "R2", "first transfer-gate edge", rise, len + 1);
    check(m_tg == 0, "R2", "transfer-gate mismatches", m_tg, 0);
    // R4: static window, R3: readout phases
    check(m_win == 0, "R4", "shift clocks in transfer window", m_win, 0);
    check(m_rd == 0, "R3", "shift clocks in readout", m_rd, 0);
    if (mode) check(m_rc == 0, "R6", "line-clamp reset/clamp mismatches", m_rc, 0);
    else      check(m_rc == 0, "R5", "bit-clamp reset/clamp mismatches", m_rc, 0);
    check(m_st == 0, "R7", "strobe/index mismatches", m_st, 0);
    if (i >= 3) check(strobes == SC_STROBES[i], "R9", "strobes in truncated lines", strobes, SC_STROBES[i]);
    else        check(strobes == SC_STROBES[i], "R7", "strobes per two lines", strobes, SC_STROBES[i]);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_levels("levels during power-up reset");

    for (int i = 0; i < NSC; i++) run_scenario(i);

    // R1: reset asserted in the middle of readout
    start(1);
    repeat (700) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_levels("levels one edge after mid-line reset");
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_reset_levels("levels held during reset");
    rst = 1'b0;
    begin
      int rise;
      rise = -1;
      for (int k = 1; k <= 600; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (tg_o && rise < 0) rise = k;
      end
      check(rise == 501, "R2", "transfer-gate edge after re-reset", rise, 501);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule